// File: doc/BRIEF.md
# Bidirectional GPIO Port with Analog-Select

This block is the register and pin-control logic for one general-purpose I/O port of a small microcontroller. It holds three per-bit controls for each pin: a direction bit, an output latch, and an analog-select bit. The analog-select bit decides whether the pin's digital input path is usable or held low so that the pin can serve an analog converter. The CPU reaches these controls through a simple register bus. The pad side gets a drive value and a driver enable for each pin and returns the sampled pin level.

A plain read of the data address returns the synchronized pin levels, masked by the analog-select bits. A read marked as read-modify-write returns the output latch instead, so bit-set and bit-clear sequences do not corrupt output bits on a port that mixes inputs and outputs.

Reset floats every pin and inhibits every digital input. Reset leaves the output latch as it was. In stop mode, a standby float control releases every driver.

Top module: `gpio_port`

## Requirements
- R1: With its direction bit at 1, a pin has pad_oe high and pad_out equal to its output-latch bit. With its direction bit at 0, its pad_oe is low.
- R2: While rst_n is low and after it is released, every direction bit reads 0 and pad_oe is all zeros. Every analog-select bit reads 1.
- R3: A read of address 0 with bus_rmw low returns the synchronized pad level for each bit whose analog-select bit is 0, and 0 for each bit whose analog-select bit is 1.
- R4: A read of address 0 with bus_rmw high returns the output latch for every bit, whatever the direction and analog-select settings.
- R5: A write to address 0 updates the output latch on the next clock edge, whatever the direction bits are.
- R6: When stop_mode and float_en are both 1, pad_oe is all zeros whatever the direction bits are. Either signal alone leaves pad_oe unchanged.
- R7: A pad change appears on a normal data read after two rising clock edges. It does not appear after only one.
- R8: Address 1 holds the direction bits and address 2 holds the analog-select bits. Both read back as written. A read of address 3, or any read with bus_re low, returns 0. A write to address 3 changes no register.
- R9: Reset does not alter the output latch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register address: 0 data, 1 direction, 2 analog-select |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_rmw | input | 1 | Marks a read as part of a read-modify-write |
| bus_wdata | input | WIDTH | Write data |
| bus_rdata | output | WIDTH | Read data, combinational |
| pad_in | input | WIDTH | Sampled pad levels |
| pad_out | output | WIDTH | Pad drive values |
| pad_oe | output | WIDTH | Pad driver enables |
| stop_mode | input | 1 | Stop mode is active |
| float_en | input | 1 | Standby control: float the pins in stop mode |

## Verification
The bench sweeps all direction patterns and all latch values. It checks that outputs are driven only where the direction bit is set. It also checks that a read-modify-write read returns the latch even on input pins; a design that returned pin levels there would make bit operations clobber outputs. Pad patterns are crossed with analog-select masks, so an analog-selected bit that leaked its pin level would fail. The bench samples the synchronizer one edge early and then on time, which catches a synchronizer that is too short or too long. It also exercises reset-time floating, the need for both stop controls together, and a latch that survives reset.

// File: rtl/gpio_port.sv
module gpio_port #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       bus_addr,
  input  logic             bus_we,
  input  logic             bus_re,
  input  logic             bus_rmw,
  input  logic [WIDTH-1:0] bus_wdata,
  output logic [WIDTH-1:0] bus_rdata,
  input  logic [WIDTH-1:0] pad_in,
  output logic [WIDTH-1:0] pad_out,
  output logic [WIDTH-1:0] pad_oe,
  input  logic             stop_mode,
  input  logic             float_en
);
  localparam logic [1:0] A_DATA = 2'd0;
  localparam logic [1:0] A_DIR  = 2'd1;
  localparam logic [1:0] A_ANA  = 2'd2;

  logic [WIDTH-1:0] latch_q, dir_q, ana_q, sync1_q, sync2_q;
  logic             float_all;

  always_ff @(posedge clk)
    if (bus_we && bus_addr == A_DATA) latch_q <= bus_wdata;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      dir_q   <= '0;
      ana_q   <= '1;
      sync1_q <= '0;
      sync2_q <= '0;
    end else begin
      sync1_q <= pad_in;
      sync2_q <= sync1_q;
      if (bus_we && bus_addr == A_DIR) dir_q <= bus_wdata;
      if (bus_we && bus_addr == A_ANA) ana_q <= bus_wdata;
    end

  assign float_all = stop_mode & float_en;
  assign pad_out   = latch_q;
  assign pad_oe    = float_all ? '0 : dir_q;

  always_comb begin
    bus_rdata = '0;
    if (bus_re)
      case (bus_addr)
        A_DATA:  bus_rdata = bus_rmw ? latch_q : (sync2_q & ~ana_q);
        A_DIR:   bus_rdata = dir_q;
        A_ANA:   bus_rdata = ana_q;
        default: bus_rdata = '0;
      endcase
  end
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       bus_addr,
  input logic             bus_we,
  input logic             bus_re,
  input logic             bus_rmw,
  input logic [WIDTH-1:0] bus_wdata,
  input logic [WIDTH-1:0] bus_rdata,
  input logic [WIDTH-1:0] pad_out,
  input logic [WIDTH-1:0] pad_oe,
  input logic             stop_mode,
  input logic             float_en
);
  AST_FLOAT_ALL: assert property (@(posedge clk) disable iff (!rst_n) (stop_mode && float_en) |-> pad_oe == '0); // R6
  AST_LATCH_WRITE: assert property (@(posedge clk) disable iff (!rst_n) (bus_we && bus_addr == 2'd0) |=> pad_out == $past(bus_wdata)); // R5
  AST_RMW_LATCH: assert property (@(posedge clk) disable iff (!rst_n) (bus_re && bus_rmw && bus_addr == 2'd0) |-> bus_rdata == pad_out); // R4
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (!bus_re || bus_addr == 2'd3) |-> bus_rdata == '0); // R8
  AST_DIR_WRITE: assert property (@(posedge clk) disable iff (!rst_n) (bus_we && bus_addr == 2'd1 && !stop_mode && !float_en && $past(rst_n)) |=> (!(stop_mode && float_en) -> pad_oe == $past(bus_wdata))); // R1
  AST_DIR_READBACK: assert property (@(posedge clk) disable iff (!rst_n) (bus_re && bus_addr == 2'd1 && !(stop_mode && float_en)) |-> bus_rdata == pad_oe); // R8
endmodule

bind gpio_port gpio_port_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/test_gpio_port.sv
module test_gpio_port;
  localparam int W = 8;
  logic clk = 0, rst_n = 0;
  logic [1:0] bus_addr = 0;
  logic bus_we = 0, bus_re = 0, bus_rmw = 0;
  logic [W-1:0] bus_wdata = 0, bus_rdata, pad_in = 0, pad_out, pad_oe;
  logic stop_mode = 0, float_en = 0;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  gpio_port #(.WIDTH(W)) i_gpio_port (.*);

  task automatic chk(input bit ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1;
    @(negedge clk);
    bus_we = 0;
  endtask

  task automatic rd(input logic [1:0] a, input bit rmw, input logic [W-1:0] exp, input string tag);
    bus_addr = a; bus_rmw = rmw; bus_re = 1;
    #0.5;
    chk(bus_rdata === exp, tag, bus_rdata, exp);
    bus_re = 0; bus_rmw = 0;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%h expected=%h", 8'h00, 8'h01);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    chk(pad_oe === '0, "R2 oe in reset", pad_oe, '0);
    rd(2'd1, 0, 8'h00, "R2 dir in reset");
    rd(2'd2, 0, 8'hFF, "R2 ana in reset");
    rst_n = 1;
    @(negedge clk);
    chk(pad_oe === '0, "R2 oe after reset", pad_oe, '0);

    pad_in = 8'hFF;
    repeat (3) @(negedge clk);
    rd(2'd0, 0, 8'h00, "R3 inhibited after reset");

    for (int v = 0; v < 256; v++) begin
      wr(2'd0, v[W-1:0]);
      rd(2'd0, 1, v[W-1:0], "R5 R4 latch write rmw read");
      chk(pad_out === v[W-1:0], "R5 pad_out", pad_out, v[W-1:0]);
    end

    wr(2'd0, 8'h5A);
    for (int d = 0; d < 256; d++) begin
      wr(2'd1, d[W-1:0]);
      chk(pad_oe === d[W-1:0], "R1 oe follows dir", pad_oe, d[W-1:0]);
      rd(2'd1, 0, d[W-1:0], "R8 dir readback");
      rd(2'd0, 1, 8'h5A, "R4 rmw under dir");
    end
    chk(pad_out === 8'h5A, "R1 pad_out from latch", pad_out, 8'h5A);

    for (int m = 0; m < 16; m++) begin
      logic [W-1:0] mask;
      mask = {m[3:0], ~m[3:0]};
      wr(2'd2, mask);
      rd(2'd2, 0, mask, "R8 ana readback");
      for (int p = 0; p < 256; p += 17) begin
        pad_in = p[W-1:0];
        repeat (3) @(negedge clk);
        rd(2'd0, 0, p[W-1:0] & ~mask, "R3 masked pin read");
      end
    end

    wr(2'd2, 8'h00);
    pad_in = 8'h00;
    repeat (3) @(negedge clk);
    pad_in = 8'hA5;
    @(negedge clk);
    rd(2'd0, 0, 8'h00, "R7 not after one edge");
    @(negedge clk);
    rd(2'd0, 0, 8'hA5, "R7 after two edges");

    wr(2'd1, 8'hFF);
    stop_mode = 1; float_en = 0; #0.5;
    chk(pad_oe === 8'hFF, "R6 stop alone", pad_oe, 8'hFF);
    stop_mode = 0; float_en = 1; #0.5;
    chk(pad_oe === 8'hFF, "R6 float alone", pad_oe, 8'hFF);
    stop_mode = 1; #0.5;
    chk(pad_oe === 8'h00, "R6 both float", pad_oe, 8'h00);
    stop_mode = 0; float_en = 0; #0.5;
    chk(pad_oe === 8'hFF, "R6 released", pad_oe, 8'hFF);

    wr(2'd1, 8'h0F);
    wr(2'd2, 8'h33);
    wr(2'd0, 8'hC6);
    wr(2'd3, 8'hAA);
    rd(2'd1, 0, 8'h0F, "R8 dir untouched by addr 3");
    rd(2'd2, 0, 8'h33, "R8 ana untouched by addr 3");
    rd(2'd0, 1, 8'hC6, "R8 latch untouched by addr 3");
    rd(2'd3, 0, 8'h00, "R8 unmapped read");
    bus_addr = 2'd1; bus_re = 0; #0.5;
    chk(bus_rdata === 8'h00, "R8 no read strobe", bus_rdata, 8'h00);

    wr(2'd0, 8'h3C);
    @(negedge clk); rst_n = 0;
    repeat (2) @(negedge clk); rst_n = 1;
    @(negedge clk);
    rd(2'd0, 1, 8'h3C, "R9 latch kept over reset");
    chk(pad_out === 8'h3C, "R9 pad_out kept", pad_out, 8'h3C);
    chk(pad_oe === 8'h00, "R2 oe after second reset", pad_oe, 8'h00);
    rd(2'd2, 0, 8'hFF, "R2 ana after second reset");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule